// File: doc/BRIEF.md
# Relocatable Page RAM Decoder with Boot-Time Map Lock

This block holds a 256-byte synchronous RAM and decodes it into a 16-bit, 64 KB CPU address space. An 8-bit mapping register picks the 4 KB page whose first 256 bytes hold the RAM. Its upper nibble supplies address bits 15:12. Its lower nibble is stored and read back but takes no part in decoding. The register itself answers at a fixed address, 0x1F3D, which never moves. That address has bits 11:8 nonzero, so it can never collide with the RAM.

In normal mode the mapping register is open for writing only during the first 64 running clock cycles after reset. After that it locks until the next reset. In special mode the lock is lifted. A stop input models a halted clock: while it is high, the RAM, the mapping register, the window counter and the read-data output all keep their values, however long the stop lasts.

Reads are synchronous. A read strobe in one cycle presents data on `bus_rdata` after the next clock edge, and that value holds until the next accepted read.

Top module: `reloc_ram_decoder`

## Requirements
- R1: A synchronous reset clears the mapping register to 0x00, which places the RAM at 0x0000–0x00FF. It clears `bus_rdata` to 0x00 and reopens the write window.
- R2: An access hits the RAM only when address bits 15:12 equal mapping register bits 7:4 and address bits 11:8 are zero. Address bits 7:0 select the byte.
- R3: A read that hits neither the RAM nor the mapping register returns 0x00. A write that misses changes neither the RAM nor the mapping register.
- R4: In normal mode (`special_mode`=0), a write to address 0x1F3D takes effect when it falls in one of the first 64 running cycles after reset, where the first cycle is the first clock edge with reset low.
- R5: In normal mode, writes to 0x1F3D from the 65th running cycle onward are ignored until the next reset.
- R6: With `special_mode`=1, a write to 0x1F3D takes effect in any cycle.
- R7: A read of 0x1F3D returns all 8 mapping bits. Bits 3:0 have no effect on which addresses hit the RAM.
- R8: While `stop_clk`=1, writes and reads are ignored, `bus_rdata` holds, and the window counter does not advance.
- R9: Read data appears on `bus_rdata` one clock edge after the read strobe and holds while no read is accepted.
- R10: A new mapping applies from the cycle after the register write. RAM contents are not moved, so a byte at offset k is found at the new base plus k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 = special mode, map writes always allowed |
| stop_clk | input | 1 | 1 = clocks halted, all state frozen |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
If the window counter is off by one cycle, the map write issued in exactly the 64th or 65th cycle after reset lands on the wrong side of the lock. A read of 0x1F3D shows this one cycle later. A wrong page or offset decode shows on the next read, either as 0x00 where data was expected or as a value found at an alias address. A stop that fails to freeze state shows as a changed `bus_rdata` during the stop, or as a lock that opens or closes one cycle off once the clock resumes.

// File: rtl/ramdec_pkg.sv
package ramdec_pkg;
    parameter int ADDR_W     = 16;
    parameter int DATA_W     = 8;
    parameter int PAGE_W     = 4;
    parameter int OFFS_W     = 8;
    parameter int WIN_CYCLES = 64;
    parameter logic [ADDR_W-1:0] MAP_ADDR = 16'h1F3D;

    localparam int WIN_CNT_W = $clog2(WIN_CYCLES + 1);
    localparam int GAP_W     = ADDR_W - PAGE_W - OFFS_W;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RAM  = 2'd1,
        SEL_MAP  = 2'd2
    } sel_e;

    function automatic logic page_hit(input logic [ADDR_W-1:0] a,
                                      input logic [PAGE_W-1:0] page);
        return (a[ADDR_W-1 -: PAGE_W] == page) &&
               (a[ADDR_W-PAGE_W-1 -: GAP_W] == '0);
    endfunction
endpackage

// File: rtl/ramdec_window.sv
module ramdec_window
    import ramdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic win_open
);
    logic [WIN_CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (run && (cnt_q < WIN_CNT_W'(WIN_CYCLES)))
            cnt_q <= cnt_q + 1'b1;
    end

    assign win_open = (cnt_q < WIN_CNT_W'(WIN_CYCLES));

    // R5: once closed, the window stays closed until reset
    assert_window_latched_R5: assert property (@(posedge clk) disable iff (rst)
        !win_open |=> !win_open);
    // R8: a stopped clock does not advance the window
    assert_window_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q));
    // R5: counter saturates
    assert_window_sat_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= WIN_CNT_W'(WIN_CYCLES));
endmodule

// File: rtl/ramdec_decode.sv
module ramdec_decode
    import ramdec_pkg::*;
(
    input  bus_req_t           req,
    input  logic [PAGE_W-1:0]  page,
    output sel_e               sel,
    output logic [OFFS_W-1:0]  offset
);
    always_comb begin
        if (req.addr == MAP_ADDR)
            sel = SEL_MAP;
        else if (page_hit(req.addr, page))
            sel = SEL_RAM;
        else
            sel = SEL_NONE;
    end

    assign offset = req.addr[OFFS_W-1:0];
endmodule

// File: rtl/ramdec_map_reg.sv
module ramdec_map_reg
    import ramdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              special_mode,
    input  logic              win_open,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] map_q
);
    logic accept;
    assign accept = run && wr_req && (special_mode || win_open);

    always_ff @(posedge clk) begin
        if (rst)
            map_q <= '0;
        else if (accept)
            map_q <= wdata;
    end

    // R1: reset clears the mapping
    assert_map_reset_R1: assert property (@(posedge clk)
        rst |=> (map_q == '0));
    // R5: normal mode with closed window leaves mapping untouched
    assert_map_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (!special_mode && !win_open) |=> $stable(map_q));
    // R8: frozen while the clock is stopped
    assert_map_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(map_q));
endmodule

// File: rtl/ramdec_ram_array.sv
module ramdec_ram_array
    import ramdec_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [OFFS_W-1:0] offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[offset] <= wdata;
        if (re)
            rdata <= mem[offset];
    end
endmodule

// File: rtl/reloc_ram_decoder.sv
module reloc_ram_decoder
    import ramdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              special_mode,
    input  logic              stop_clk,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    bus_req_t          req;
    sel_e              sel, sel_q;
    logic              run, win_open;
    logic [OFFS_W-1:0] offset;
    logic [DATA_W-1:0] map_q, map_rd_q, ram_q;

    assign run = !stop_clk;
    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    ramdec_window u_window (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .win_open (win_open)
    );

    // decode uses the mapping in force before any update this cycle (R10)
    ramdec_decode u_decode (
        .req    (req),
        .page   (map_q[DATA_W-1 -: PAGE_W]),
        .sel    (sel),
        .offset (offset)
    );

    ramdec_map_reg u_map (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .special_mode (special_mode),
        .win_open     (win_open),
        .wr_req       (req.wr && (sel == SEL_MAP)),
        .wdata        (req.wdata),
        .map_q        (map_q)
    );

    ramdec_ram_array u_ram (
        .clk    (clk),
        .we     (run && req.wr && (sel == SEL_RAM)),
        .re     (run && req.rd && (sel == SEL_RAM)),
        .offset (offset),
        .wdata  (req.wdata),
        .rdata  (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= SEL_NONE;
            map_rd_q <= '0;
        end else if (run && req.rd) begin
            sel_q    <= sel;
            map_rd_q <= map_q;
        end
    end

    always_comb begin
        unique case (sel_q)
            SEL_RAM: bus_rdata = ram_q;
            SEL_MAP: bus_rdata = map_rd_q;
            default: bus_rdata = '0;
        endcase
    end

    // R3: a missed read returns zero
    assert_rdata_miss_R3: assert property (@(posedge clk) disable iff (rst)
        (run && req.rd && (sel == SEL_NONE)) |=> (bus_rdata == '0));
    // R9 / R8: read data holds when no read is accepted
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(run && req.rd) |=> $stable(bus_rdata));
    // R7: mapping read returns the register value
    assert_map_read_R7: assert property (@(posedge clk) disable iff (rst)
        (run && req.rd && (sel == SEL_MAP)) |=> (bus_rdata == $past(map_q)));
endmodule

// File: tb/reloc_ram_decoder_tb.sv
`timescale 1ns/1ps
module reloc_ram_decoder_tb_top;
    localparam logic [15:0] MAPA = 16'h1F3D;
    localparam logic [1:0] K_IDLE = 2'd0, K_WR = 2'd1, K_RD = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
    } vec_t;

    // walked in special mode after a reset
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{K_WR, 16'h0000, 8'hA5, 8'h00},
        '{K_WR, 16'h00FF, 8'h3C, 8'h00},
        '{K_RD, 16'h0000, 8'h00, 8'hA5},   // R2
        '{K_RD, 16'h00FF, 8'h00, 8'h3C},   // R2
        '{K_RD, 16'h0100, 8'h00, 8'h00},   // R2 bits 11:8 nonzero
        '{K_WR, 16'h0100, 8'h77, 8'h00},   // R3 miss write
        '{K_RD, 16'h0000, 8'h00, 8'hA5},   // R3 no alias
        '{K_RD, 16'h8000, 8'h00, 8'h00},   // R3 miss read
        '{K_WR, MAPA,     8'h5B, 8'h00},   // R6
        '{K_RD, MAPA,     8'h00, 8'h5B},   // R7
        '{K_RD, 16'h5000, 8'h00, 8'hA5},   // R10
        '{K_RD, 16'h0000, 8'h00, 8'h00},   // R10 old page gone
        '{K_RD, 16'h50FF, 8'h00, 8'h3C},   // R10
        '{K_WR, 16'h5010, 8'hC3, 8'h00},
        '{K_WR, MAPA,     8'h57, 8'h00},   // R7 lower nibble change
        '{K_RD, 16'h5010, 8'h00, 8'hC3},   // R7
        '{K_WR, MAPA,     8'hF0, 8'h00},
        '{K_RD, 16'hF010, 8'h00, 8'hC3},   // R2 top page
        '{K_RD, 16'hF110, 8'h00, 8'h00},   // R2
        '{K_RD, MAPA,     8'h00, 8'hF0}    // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        special_mode = 1'b0;
    logic        stop_clk = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    reloc_ram_decoder dut_i (
        .clk          (clk),
        .rst          (rst),
        .special_mode (special_mode),
        .stop_clk     (stop_clk),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_rdata    (bus_rdata)
    );

    // one bus cycle: drive at a falling edge, return at the next falling edge
    task automatic op(input logic [1:0] kind, input logic [15:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = (kind == K_WR);
        bus_rd    = (kind == K_RD);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(K_IDLE, 16'h0000, 8'h00);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 rdata after reset", bus_rdata, 8'h00);

        // window accepted on its last cycle
        op(K_RD, MAPA, 8'h00);                       // cycle 1
        check("R1 map reset value", bus_rdata, 8'h00);
        op(K_WR, 16'h0000, 8'h11);                   // cycle 2
        op(K_RD, 16'h0000, 8'h00);                   // cycle 3
        check("R1 RAM at page 0", bus_rdata, 8'h11);
        idle(60);                                    // cycles 4..63
        op(K_WR, MAPA, 8'h30);                       // cycle 64
        op(K_RD, MAPA, 8'h00);
        check("R4 write in cycle 64", bus_rdata, 8'h30);
        op(K_WR, MAPA, 8'h40);
        op(K_RD, MAPA, 8'h00);
        check("R5 locked after window", bus_rdata, 8'h30);
        op(K_RD, 16'h3000, 8'h00);
        check("R10 relocated contents", bus_rdata, 8'h11);
        op(K_IDLE, 16'h0000, 8'h00);
        check("R9 hold without read", bus_rdata, 8'h11);

        // write in cycle 65 rejected
        do_reset();
        idle(64);
        op(K_WR, MAPA, 8'h70);                       // cycle 65
        op(K_RD, MAPA, 8'h00);
        check("R5 write in cycle 65", bus_rdata, 8'h00);
        special_mode = 1'b1;
        op(K_WR, MAPA, 8'h70);
        op(K_RD, MAPA, 8'h00);
        check("R6 special-mode write", bus_rdata, 8'h70);
        special_mode = 1'b0;
        op(K_WR, MAPA, 8'h80);
        op(K_RD, MAPA, 8'h00);
        check("R5 lock resumes", bus_rdata, 8'h70);

        // stop freezes everything
        do_reset();
        idle(60);                                    // cycles 1..60
        op(K_RD, 16'h0000, 8'h00);                   // cycle 61
        check("R9 read before stop", bus_rdata, 8'h11);
        stop_clk = 1'b1;
        for (int i = 0; i < 7; i++) begin
            op(K_WR, MAPA, 8'h90);
            op(K_WR, 16'h0000, 8'hEE);
            op(K_RD, 16'h0100, 8'h00);
        end
        check("R8 rdata held in stop", bus_rdata, 8'h11);
        stop_clk = 1'b0;
        op(K_RD, MAPA, 8'h00);                       // cycle 62
        check("R8 map write ignored in stop", bus_rdata, 8'h00);
        op(K_WR, MAPA, 8'h90);                       // cycle 63
        op(K_RD, MAPA, 8'h00);
        check("R8 window frozen in stop", bus_rdata, 8'h90);
        op(K_RD, 16'h9000, 8'h00);
        check("R8 RAM write ignored in stop", bus_rdata, 8'h11);

        // vector table in special mode
        do_reset();
        special_mode = 1'b1;
        for (int v = 0; v < NV; v++) begin
            op(VECS[v].kind, VECS[v].addr, VECS[v].data);
            if (VECS[v].kind == K_RD)
                check($sformatf("R2/R3/R7/R10 vector %0d", v), bus_rdata, VECS[v].exp);
        end
        special_mode = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule